// File: doc/BRIEF.md
# Private Memory Bus Master

This block is the processor-side controller for a fast private path to memory. The path shares its address and data lines with a slower, fully handshaked system bus. A local request port takes four kinds of access: read, read-pause, word write and byte write. For each access the block runs a short address phase and then asks the memory to claim the cycle. If the memory claims it, the transfer proceeds with strobes only. A read returns two words, the requested one first and then its partner in the aligned word pair, together with per-word parity status. If no private memory claims the cycle, the block drops it and raises a one-cycle `fallback` flag, so that ordinary bus logic outside this block can run the access instead.

Before it starts any cycle, the block applies the bus turnaround rules. These depend on what happened last on the bus, which is reported on `last_kind`. The block also waits for the memory's reply and buffer-full lines to clear. After a read-pause it locks the request port. While the lock holds, only a write to the same address gets through.

Both edges of the local port are valid/ready. A request transfers when `req_valid` and `req_ready` are high at a clock edge. `req_ready` depends only on block state, the bus inputs and the request payload, never on `req_valid`. Read results stay on the response port, unchanged, from the cycle `rsp_valid` rises until the cycle after `rsp_ready` is seen high. While a response waits, no new request is taken. Writes and fallbacks produce no response.

Top module: `pmb_master`

## Requirements
- R1: After reset, `pbcyc`, `wtstb`, `addr_oe`, `data_oe`, `bus_iopage`, `rsp_valid` and `fallback` are low, and both type lines `wtbt_n` and `pbyt_n` are high.
- R2: During the address phase the type lines carry the access kind, both active low. Read: `wtbt_n`=1, `pbyt_n`=1. Read-pause: `wtbt_n`=1, `pbyt_n`=0. Word write: `wtbt_n`=0, `pbyt_n`=1. Byte write: `wtbt_n`=0, `pbyt_n`=0. On `req_kind` these kinds are coded 0, 1, 2 and 3.
- R3: The address phase drives `bus_addr` with `addr_oe` high for at least one cycle before `pbcyc` rises. `bus_iopage` is high only when address bits [AW-1:IO_BITS] are all ones. When `pbcyc` rises, `pbyt_n` is released, while the address, `bus_iopage` and `wtbt_n` stay driven for HOLD_CYC more cycles.
- R4: At the end of the address phase, if `sel_in` is low or `pubmem_in` is high, no `pbcyc` is issued. If `sel_in` drops during the hold window after `pbcyc` rose, the private cycle is abandoned. In both cases `fallback` pulses for one cycle and no response is produced.
- R5: Turnaround, selected by `last_kind`. 0: the last cycle was private, with no extra wait. 1: this master's own bus cycle; the block waits for `sync_in` and `reply_in` to be low. 2: an interrupt-service cycle; the block waits only for `reply_in` to be low. 3: another master owned the bus; the block waits for `sync_in` to be low.
- R6: On a read, word 0 is taken from `bus_data_in` in the cycle where `rdstb_in` is first seen low after being high. Word 1 is taken exactly SECOND_DLY cycles later with no further handshake. `pbcyc` is then negated and the response presents both words with `rsp_tag` equal to the requested address.
- R7: On a write, `bus_data_out` carries the request data with `data_oe` high from the cycle after `pbcyc` rises. `wtstb` rises only after that and stays high for WSTB_CYC cycles. `wtstb` falls at least one cycle before `pbcyc` falls.
- R8: Read parity is odd over the high byte plus `par_hi_in`, and even over the low byte plus `par_lo_in`. A mismatch in word 0 sets `rsp_perr[0]` and a mismatch in word 1 sets `rsp_perr[1]`.
- R9: No new cycle starts (`req_ready` stays low and no address phase begins) while `reply_in` or `sbful_in` is high.
- R10: After a completed read-pause, `req_ready` stays low for every request except a word or byte write to the same address. Accepting that write releases the lock.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response holds its data, tag and parity bits, and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 0 read, 1 read-pause, 2 word write, 3 byte write |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Read result taken |
| rsp_data0 | output | 16 | Word at the requested address |
| rsp_data1 | output | 16 | Partner word of the aligned pair |
| rsp_tag | output | AW | Address of the first word |
| rsp_perr | output | 2 | Parity error per word (bit 0 = word 0) |
| fallback | output | 1 | One-cycle pulse: private cycle declined |
| last_kind | input | 2 | Kind of the previous bus cycle (see R5) |
| sync_in | input | 1 | Bus sync line, active high |
| reply_in | input | 1 | Memory or bus reply, active high |
| sbful_in | input | 1 | Memory write buffer full, active high |
| sel_in | input | 1 | Private slave selected, active high |
| pubmem_in | input | 1 | Public memory responding, active high |
| rdstb_in | input | 1 | Read strobe from memory, active high |
| bus_data_in | input | 16 | Data lines as received |
| par_hi_in | input | 1 | High-byte parity bit |
| par_lo_in | input | 1 | Low-byte parity bit |
| bus_addr | output | AW | Address lines (zero when not driven) |
| addr_oe | output | 1 | Address lines driven |
| bus_iopage | output | 1 | I/O-page select |
| wtbt_n | output | 1 | Write-byte type line, active low |
| pbyt_n | output | 1 | Private-byte type line, active low |
| pbcyc | output | 1 | Private bus cycle, active high |
| bus_data_out | output | 16 | Write data lines |
| data_oe | output | 1 | Write data driven |
| wtstb | output | 1 | Write strobe, active high |

## Verification
The hardest state to reach from the ports is a memory that claims the address and then withdraws its select during the short hold window after `pbcyc` has risen. The bench memory model has a knob that drops `sel_in` at the first falling clock edge where it sees `pbcyc`. This exercises the late abandonment path, which differs from the early decline at the end of the address phase. Second-word timing is just as narrow. The model puts a decoy value on the data lines while the strobe is high, and another decoy in the cycles before the delay expires. A latch taken one cycle early or late therefore returns a decoy instead of the expected word.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_RPAUSE = 2'd1,
    K_WRITE  = 2'd2,
    K_WBYTE  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    L_PRIVATE  = 2'd0,
    L_OWN_BUS  = 2'd1,
    L_OWN_INTR = 2'd2,
    L_OTHER    = 2'd3
  } last_cycle_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_HOLD, S_RWAIT, S_RSEC, S_RESP, S_WDATA, S_WSTB, S_WEND
  } state_e;
endpackage

// File: rtl/pmb_turn.sv
`timescale 1ns/1ps
module pmb_turn
  import pmb_pkg::*;
(
  input  logic [1:0] last_kind,
  input  logic       sync_in,
  input  logic       reply_in,
  input  logic       sbful_in,
  output logic       clear
);
  logic sync_wait;

  always_comb begin
    case (last_cycle_e'(last_kind))
      L_OWN_BUS, L_OTHER: sync_wait = sync_in;
      default:            sync_wait = 1'b0;
    endcase
    clear = !reply_in && !sbful_in && !sync_wait;
  end
endmodule

// File: rtl/pmb_parchk.sv
`timescale 1ns/1ps
module pmb_parchk
  import pmb_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic              par_hi,
  input  logic              par_lo,
  output logic              err
);
  localparam int HALF = WORD_W / 2;
  logic hi_bad, lo_bad;

  always_comb begin
    hi_bad = ~^{data[WORD_W-1:HALF], par_hi};
    lo_bad = ^{data[HALF-1:0], par_lo};
    err    = hi_bad || lo_bad;
  end
endmodule

// File: rtl/pmb_master.sv
`timescale 1ns/1ps
module pmb_master
  import pmb_pkg::*;
#(
  parameter int AW         = 22,
  parameter int IO_BITS    = 13,
  parameter int HOLD_CYC   = 1,
  parameter int SECOND_DLY = 6,
  parameter int WSTB_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data0,
  output logic [WORD_W-1:0] rsp_data1,
  output logic [AW-1:0]     rsp_tag,
  output logic [1:0]        rsp_perr,
  output logic              fallback,
  input  logic [1:0]        last_kind,
  input  logic              sync_in,
  input  logic              reply_in,
  input  logic              sbful_in,
  input  logic              sel_in,
  input  logic              pubmem_in,
  input  logic              rdstb_in,
  input  logic [WORD_W-1:0] bus_data_in,
  input  logic              par_hi_in,
  input  logic              par_lo_in,
  output logic [AW-1:0]     bus_addr,
  output logic              addr_oe,
  output logic              bus_iopage,
  output logic              wtbt_n,
  output logic              pbyt_n,
  output logic              pbcyc,
  output logic [WORD_W-1:0] bus_data_out,
  output logic              data_oe,
  output logic              wtstb
);
  localparam int CMAX0 = (SECOND_DLY > WSTB_CYC) ? SECOND_DLY : WSTB_CYC;
  localparam int CMAX  = (CMAX0 > HOLD_CYC) ? CMAX0 : HOLD_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  state_e            st;
  logic [CW-1:0]     cnt;
  req_kind_e         kind_q;
  logic [AW-1:0]     addr_q, lock_addr_q;
  logic [WORD_W-1:0] wdata_q, d0_q, d1_q;
  logic [1:0]        perr_q;
  logic              lock_q, rdstb_q, fb_q;
  logic              gate_ok, par_err, lock_ok, fire, is_wr_q;

  pmb_turn u_turn (
    .last_kind(last_kind), .sync_in(sync_in), .reply_in(reply_in),
    .sbful_in(sbful_in), .clear(gate_ok)
  );

  pmb_parchk u_par (
    .data(bus_data_in), .par_hi(par_hi_in), .par_lo(par_lo_in), .err(par_err)
  );

  // request port
  assign lock_ok   = !lock_q || (req_kind[1] && req_addr == lock_addr_q);
  assign req_ready = (st == S_IDLE) && gate_ok && lock_ok;
  assign fire      = req_valid && req_ready;
  assign is_wr_q   = kind_q[1];

  // bus side
  assign addr_oe      = (st == S_ADDR) || (st == S_HOLD);
  assign bus_addr     = addr_oe ? addr_q : '0;
  assign bus_iopage   = addr_oe && (&addr_q[AW-1:IO_BITS]);
  assign wtbt_n       = !(addr_oe && is_wr_q);
  assign pbyt_n       = !((st == S_ADDR) && (kind_q == K_RPAUSE || kind_q == K_WBYTE));
  assign pbcyc        = st inside {S_HOLD, S_RWAIT, S_RSEC, S_WDATA, S_WSTB, S_WEND};
  assign data_oe      = st inside {S_WDATA, S_WSTB, S_WEND};
  assign bus_data_out = data_oe ? wdata_q : '0;
  assign wtstb        = (st == S_WSTB);

  // response port
  assign rsp_valid = (st == S_RESP);
  assign rsp_data0 = d0_q;
  assign rsp_data1 = d1_q;
  assign rsp_tag   = addr_q;
  assign rsp_perr  = perr_q;
  assign fallback  = fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      kind_q      <= K_READ;
      addr_q      <= '0;
      lock_addr_q <= '0;
      wdata_q     <= '0;
      d0_q        <= '0;
      d1_q        <= '0;
      perr_q      <= '0;
      lock_q      <= 1'b0;
      rdstb_q     <= 1'b0;
      fb_q        <= 1'b0;
    end else begin
      fb_q    <= 1'b0;
      rdstb_q <= rdstb_in;
      case (st)
        S_IDLE: if (fire) begin
          kind_q  <= req_kind_e'(req_kind);
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          lock_q  <= 1'b0;
          st      <= S_ADDR;
        end
        S_ADDR: if (sel_in && !pubmem_in) begin
          cnt <= '0;
          st  <= S_HOLD;
        end else begin
          fb_q <= 1'b1;
          st   <= S_IDLE;
        end
        S_HOLD: if (!sel_in) begin
          fb_q <= 1'b1;
          st   <= S_IDLE;
        end else if (cnt == CW'(HOLD_CYC - 1)) begin
          cnt <= '0;
          st  <= is_wr_q ? S_WDATA : S_RWAIT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_RWAIT: if (rdstb_q && !rdstb_in) begin
          d0_q      <= bus_data_in;
          perr_q[0] <= par_err;
          cnt       <= '0;
          st        <= S_RSEC;
        end
        S_RSEC: if (cnt == CW'(SECOND_DLY - 1)) begin
          d1_q        <= bus_data_in;
          perr_q[1]   <= par_err;
          lock_q      <= (kind_q == K_RPAUSE);
          lock_addr_q <= addr_q;
          st          <= S_RESP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        S_WDATA: begin
          cnt <= '0;
          st  <= S_WSTB;
        end
        S_WSTB: if (cnt == CW'(WSTB_CYC - 1)) st <= S_WEND;
                else cnt <= cnt + 1'b1;
        S_WEND: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  wtstb_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wtstb |-> pbcyc && data_oe);
  // R7
  wtstb_falls_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wtstb) |-> pbcyc);
  // R3
  addr_before_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pbcyc) |-> addr_oe && $past(addr_oe) && pbyt_n);
  // R2
  type_in_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pbyt_n |-> addr_oe && !pbcyc);
  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> $past(!reply_in && !sbful_in));
  // R4
  fallback_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> !pbcyc && !rsp_valid && $past(addr_oe));
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data0) && $stable(rsp_data1)
      && $stable(rsp_tag) && $stable(rsp_perr));
  // R10
  lock_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) && $past(lock_q) |-> kind_q[1] && addr_q == $past(lock_addr_q));
endmodule

// File: tb/tb_pmb_master.sv
`timescale 1ns/1ps
module tb_pmb_master;
  localparam int AW = 22;
  localparam int D  = 6;
  localparam logic [15:0] DECOY1 = 16'hDEAD;
  localparam logic [15:0] DECOY2 = 16'hBEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_data0, rsp_data1;
  logic [AW-1:0] rsp_tag;
  logic [1:0] rsp_perr;
  logic fallback;
  logic [1:0] last_kind = 2'd0;
  logic sync_in = 1'b0, reply_in = 1'b0, sbful_in = 1'b0;
  logic sel_in = 1'b0, pubmem_in = 1'b0, rdstb_in = 1'b0;
  logic [15:0] bus_data_in = '0;
  logic par_hi_in = 1'b0, par_lo_in = 1'b0;
  logic [AW-1:0] bus_addr;
  logic addr_oe, bus_iopage, wtbt_n, pbyt_n, pbcyc, data_oe, wtstb;
  logic [15:0] bus_data_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pmb_master #(.AW(AW), .IO_BITS(13), .HOLD_CYC(1), .SECOND_DLY(D), .WSTB_CYC(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data0(rsp_data0),
    .rsp_data1(rsp_data1), .rsp_tag(rsp_tag), .rsp_perr(rsp_perr),
    .fallback(fallback), .last_kind(last_kind), .sync_in(sync_in),
    .reply_in(reply_in), .sbful_in(sbful_in), .sel_in(sel_in),
    .pubmem_in(pubmem_in), .rdstb_in(rdstb_in), .bus_data_in(bus_data_in),
    .par_hi_in(par_hi_in), .par_lo_in(par_lo_in), .bus_addr(bus_addr),
    .addr_oe(addr_oe), .bus_iopage(bus_iopage), .wtbt_n(wtbt_n), .pbyt_n(pbyt_n),
    .pbcyc(pbcyc), .bus_data_out(bus_data_out), .data_oe(data_oe), .wtstb(wtstb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // memory model knobs and data
  bit k_nosel = 0, k_pub = 0, k_drop = 0, k_bad_hi0 = 0, k_bad_lo1 = 0;
  logic [15:0] m_w0 = '0, m_w1 = '0;

  function automatic logic hi_par(input logic [15:0] d, input bit bad);
    return ~(^d[15:8]) ^ bad;
  endfunction
  function automatic logic lo_par(input logic [15:0] d, input bit bad);
    return (^d[7:0]) ^ bad;
  endfunction

  initial begin : mem_model
    int m_cnt;
    bit m_rd;
    m_cnt = 0;
    m_rd = 0;
    forever begin
      @(negedge clk);
      if (addr_oe || pbcyc) begin
        sel_in    = !k_nosel && !(k_drop && pbcyc);
        pubmem_in = k_pub;
      end else begin
        sel_in    = 1'b0;
        pubmem_in = 1'b0;
      end
      if (addr_oe && !pbcyc) m_rd = wtbt_n;
      if (pbcyc && m_rd) begin
        m_cnt++;
        if (m_cnt == 2) begin
          bus_data_in = DECOY1; rdstb_in = 1'b1;
        end else if (m_cnt == 3) begin
          bus_data_in = m_w0;
          par_hi_in = hi_par(m_w0, k_bad_hi0);
          par_lo_in = lo_par(m_w0, 1'b0);
        end else if (m_cnt == 4) begin
          rdstb_in = 1'b0;
        end else if (m_cnt >= 5 && m_cnt < 4 + D) begin
          bus_data_in = DECOY2;
        end else if (m_cnt >= 4 + D) begin
          bus_data_in = m_w1;
          par_hi_in = hi_par(m_w1, 1'b0);
          par_lo_in = lo_par(m_w1, k_bad_lo1);
        end
      end else begin
        m_cnt = 0;
        rdstb_in = 1'b0;
        bus_data_in = '0;
      end
    end
  end

  // bus monitor (outputs only)
  bit ap_seen;
  logic [AW-1:0] ap_addr;
  logic ap_io, ap_wtbt, ap_pbyt, cy_pbyt, cy_aoe, cy_wtbt, stb_late, fell_ok;
  logic [15:0] wd_seen;
  int fb_cnt, cyc_cnt, fall_cnt, rsp_cnt;
  logic pb_prev = 0, ws_prev = 0;

  task automatic clear_mon();
    ap_seen = 0; ap_addr = '0; ap_io = 0; ap_wtbt = 1; ap_pbyt = 1;
    cy_pbyt = 0; cy_aoe = 0; cy_wtbt = 1; stb_late = 0; fell_ok = 0; wd_seen = '0;
    fb_cnt = 0; cyc_cnt = 0; fall_cnt = 0; rsp_cnt = 0;
  endtask

  initial begin : monitor
    clear_mon();
    forever begin
      @(negedge clk);
      if (addr_oe && !pbcyc && !ap_seen) begin
        ap_seen = 1; ap_addr = bus_addr; ap_io = bus_iopage;
        ap_wtbt = wtbt_n; ap_pbyt = pbyt_n;
      end
      if (pbcyc && !pb_prev) begin
        cyc_cnt++; cy_pbyt = pbyt_n; cy_aoe = addr_oe; cy_wtbt = wtbt_n;
      end
      if (!pbcyc && pb_prev) fall_cnt++;
      if (wtstb && !ws_prev) begin
        wd_seen = bus_data_out; stb_late = pb_prev && data_oe;
      end
      if (!wtstb && ws_prev) fell_ok = pbcyc;
      if (fallback) fb_cnt++;
      if (rsp_valid) rsp_cnt++;
      pb_prev = pbcyc;
      ws_prev = wtstb;
    end
  end

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [15:0] d, output bit ok);
    ok = 0;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = d;
    for (int i = 0; i < 60; i++) begin
      #1;
      if (req_ready) begin
        ok = 1;
        break;
      end
      @(negedge clk);
    end
    if (ok) begin
      @(posedge clk);
      #1;
    end
    req_valid = 0;
  endtask

  task automatic probe(input logic [1:0] k, input logic [AW-1:0] a, output logic rdy);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a;
    #1 rdy = req_ready;
    req_valid = 0;
  endtask

  task automatic wait_rsp(output bit ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic do_read(input logic [1:0] k, input logic [AW-1:0] a,
                         input logic [15:0] w0, input logic [15:0] w1,
                         input logic [1:0] exp_perr, input string tag);
    bit ok;
    m_w0 = w0; m_w1 = w1;
    clear_mon();
    issue(k, a, 16'h0, ok);
    check(ok, "R9", {tag, " request accepted"}, ok, 1);
    wait_rsp(ok);
    check(ok, "R6", {tag, " response arrives"}, ok, 1);
    check(rsp_data0 == w0, "R6", {tag, " word0"}, rsp_data0, w0);
    check(rsp_data1 == w1, "R6", {tag, " word1"}, rsp_data1, w1);
    check(rsp_tag == a, "R6", {tag, " tag"}, rsp_tag, a);
    check(!pbcyc && fall_cnt == 1, "R6", {tag, " pbcyc negated"}, pbcyc, 0);
    check(rsp_perr == exp_perr, "R8", {tag, " parity"}, rsp_perr, exp_perr);
    check(ap_wtbt == 1'b1 && ap_pbyt == (k == 2'd1 ? 1'b0 : 1'b1), "R2",
          {tag, " type lines"}, {ap_wtbt, ap_pbyt}, {1'b1, k != 2'd1});
    check(ap_addr == a && ap_io == (&a[AW-1:13]), "R3", {tag, " address phase"},
          {ap_io, ap_addr}, {&a[AW-1:13], a});
    check(cy_pbyt && cy_aoe && cy_wtbt, "R3", {tag, " hold after pbcyc"},
          {cy_pbyt, cy_aoe, cy_wtbt}, 3'b111);
    if (rsp_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] k, input logic [AW-1:0] a,
                          input logic [15:0] d, input string tag);
    bit ok;
    clear_mon();
    issue(k, a, d, ok);
    check(ok, "R10", {tag, " write accepted"}, ok, 1);
    for (int i = 0; i < 60 && fall_cnt == 0; i++) @(negedge clk);
    check(fall_cnt == 1, "R7", {tag, " cycle ended"}, fall_cnt, 1);
    check(wd_seen == d && stb_late, "R7", {tag, " data before strobe"},
          {stb_late, wd_seen}, {1'b1, d});
    check(fell_ok == 1'b1, "R7", {tag, " strobe falls before pbcyc"}, fell_ok, 1);
    check(ap_wtbt == 1'b0 && ap_pbyt == (k == 2'd3 ? 1'b0 : 1'b1), "R2",
          {tag, " type lines"}, {ap_wtbt, ap_pbyt}, {1'b0, k != 2'd3});
    check(rsp_cnt == 0, "R7", {tag, " no response"}, rsp_cnt, 0);
  endtask

  task automatic t_reset();
    check(!pbcyc && !wtstb && !addr_oe && !data_oe && !bus_iopage && !rsp_valid && !fallback
          && wtbt_n && pbyt_n, "R1", "idle outputs after reset",
          {pbcyc, wtstb, addr_oe, data_oe, bus_iopage, rsp_valid, fallback, wtbt_n, pbyt_n},
          9'b000000011);
  endtask

  task automatic t_fallback();
    bit ok;
    k_nosel = 1;
    clear_mon();
    issue(2'd0, 22'h000100, 16'h0, ok);
    repeat (8) @(negedge clk);
    check(fb_cnt == 1 && cyc_cnt == 0 && rsp_cnt == 0, "R4", "no select: early fallback",
          {fb_cnt[7:0], cyc_cnt[7:0]}, 16'h0100);
    k_nosel = 0; k_pub = 1;
    clear_mon();
    issue(2'd2, 22'h000104, 16'h1234, ok);
    repeat (8) @(negedge clk);
    check(fb_cnt == 1 && cyc_cnt == 0 && !wtstb, "R4", "public memory: fallback",
          {fb_cnt[7:0], cyc_cnt[7:0]}, 16'h0100);
    k_pub = 0; k_drop = 1;
    clear_mon();
    issue(2'd0, 22'h000108, 16'h0, ok);
    repeat (10) @(negedge clk);
    check(fb_cnt == 1 && cyc_cnt == 1 && fall_cnt == 1 && rsp_cnt == 0, "R4",
          "select dropped in hold: late fallback",
          {fb_cnt[7:0], cyc_cnt[7:0], rsp_cnt[7:0]}, 24'h010100);
    k_drop = 0;
  endtask

  task automatic t_turnaround();
    logic rdy;
    last_kind = 2'd1; sync_in = 1; reply_in = 1;
    probe(2'd0, 22'h000200, rdy);
    check(!rdy && !addr_oe, "R5", "own bus cycle: sync and reply high", rdy, 0);
    reply_in = 0;
    probe(2'd0, 22'h000200, rdy);
    check(!rdy, "R5", "own bus cycle: sync still high", rdy, 0);
    sync_in = 0;
    do_read(2'd0, 22'h000200, 16'h1111, 16'h2222, 2'b00, "R5 own bus released");
    last_kind = 2'd2; sync_in = 1;
    do_read(2'd0, 22'h000204, 16'h3333, 16'h4444, 2'b00, "R5 interrupt ignores sync");
    last_kind = 2'd3;
    probe(2'd0, 22'h000208, rdy);
    check(!rdy, "R5", "other master: sync high", rdy, 0);
    sync_in = 0;
    do_read(2'd0, 22'h000208, 16'h5555, 16'h6666, 2'b00, "R5 other master released");
    last_kind = 2'd0;
  endtask

  task automatic t_reply_gate();
    logic rdy;
    reply_in = 1;
    probe(2'd2, 22'h000300, rdy);
    check(!rdy, "R9", "reply high blocks start", rdy, 0);
    reply_in = 0; sbful_in = 1;
    probe(2'd2, 22'h000300, rdy);
    check(!rdy, "R9", "buffer full blocks start", rdy, 0);
    repeat (3) @(negedge clk);
    check(!addr_oe && !pbcyc, "R9", "no address phase while blocked", addr_oe, 0);
    sbful_in = 0;
    probe(2'd2, 22'h000300, rdy);
    check(rdy, "R9", "released after lines clear", rdy, 1);
  endtask

  task automatic t_lock();
    logic rdy;
    do_read(2'd1, 22'h000402, 16'hA5A5, 16'h5A5A, 2'b00, "R10 read-pause");
    probe(2'd0, 22'h000500, rdy);
    check(!rdy, "R10", "read held off after read-pause", rdy, 0);
    probe(2'd2, 22'h000404, rdy);
    check(!rdy, "R10", "write elsewhere held off", rdy, 0);
    do_write(2'd3, 22'h000402, 16'h00C3, "R10 paired byte write");
    probe(2'd0, 22'h000500, rdy);
    check(rdy, "R10", "lock released after write", rdy, 1);
  endtask

  task automatic t_backpressure();
    bit ok;
    logic rdy;
    rsp_ready = 0;
    m_w0 = 16'h0F0F; m_w1 = 16'hF00D;
    clear_mon();
    issue(2'd0, 22'h000600, 16'h0, ok);
    wait_rsp(ok);
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_data0 == 16'h0F0F && rsp_data1 == 16'hF00D && rsp_tag == 22'h000600,
          "R11", "response held under back-pressure", rsp_data0, 16'h0F0F);
    probe(2'd0, 22'h000700, rdy);
    check(!rdy, "R11", "no accept while response pending", rdy, 0);
    @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    check(!rsp_valid, "R11", "response drops after accept", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    do_read(2'd0, 22'h001000, 16'h1234, 16'h8001, 2'b00, "R6 plain read even");
    do_read(2'd0, 22'h001002, 16'hFFFF, 16'h0000, 2'b00, "R6 plain read odd word");
    do_read(2'd0, 22'h3FE010, 16'h7E7E, 16'h0101, 2'b00, "R3 io page read");
    k_bad_hi0 = 1;
    do_read(2'd0, 22'h001010, 16'h00FF, 16'hFF00, 2'b01, "R8 word0 high byte bad");
    k_bad_hi0 = 0; k_bad_lo1 = 1;
    do_read(2'd0, 22'h001012, 16'h0000, 16'h1357, 2'b10, "R8 word1 low byte bad");
    k_bad_lo1 = 0;
    do_write(2'd2, 22'h002000, 16'hCAFE, "R7 word write");
    do_write(2'd3, 22'h3FE001, 16'hAB00, "R7 byte write io page");
    t_fallback();
    t_turnaround();
    t_reply_gate();
    t_lock();
    t_backpressure();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule